// File: doc/BRIEF.md
# MDIO Paged 32-bit Register Bridge

This bridge lets a 16-bit management register interface, such as the one behind a clause-22 MDIO slave, reach a 32-bit internal register space. The internal word address is composed from three parts: the page held in management register 0x1F supplies internal address bits 15:6, the number of the low-word register being accessed (0x00 to 0x0F) supplies bits 5:2, and bits 1:0 are always zero. Management register 0x10 carries the upper half (bits 31:16) of the 32-bit data word.

To read, software writes the page, reads a low-word register, then reads 0x10. The low-word read issues one 32-bit internal read. It returns bits 15:0 and keeps bits 31:16 in a shadow register, so the high half comes from the same internal access. To write, software writes the page, writes the low half to a low-word register, then writes the high half to 0x10. The low-word write only stages the data and the address. The 0x10 write then issues a single 32-bit internal write. The management side is stalled by holding back the acknowledge until the internal bus answers with ready.

Top module: `mdio_page_bridge`

## Requirements
- R1: After reset, m_ack, bus_we, bus_re and err_sticky are 0, m_rdata is 0 and the page register reads back as 0.
- R2: A write to register 0x1F stores m_wdata bits [ADDR_W-7:0] as the page; a read of 0x1F returns the page zero-extended to 16 bits, and the higher written bits are dropped.
- R3: A read of register n (0x00 to 0x0F) issues exactly one internal read at address {page, n[3:0], 2'b00} and returns bus_rdata[15:0] on m_rdata.
- R4: A read of register 0x10 makes no internal access and returns bits 31:16 of the most recently completed internal read.
- R5: A write to register n (0x00 to 0x0F) makes no internal access. A following write to 0x10 issues one internal write with data {high half, low half} at address {page at the time of the low-word write, n[3:0], 2'b00}.
- R6: An internal request (bus_re or bus_we) and its address and data stay constant until bus_ready is sampled high. m_ack rises in the cycle after that sample, so an access that waits L cycles for ready is acknowledged 2+L cycles after the request is applied.
- R7: m_rdata changes only in a cycle where m_ack is high, and it holds its value across writes and idle cycles.
- R8: A write to 0x10 with no staged low-word write makes no internal access and sets err_sticky. A completed 0x10 write uses up the staged low word. err_sticky stays high until reset.
- R9: Registers 0x11 to 0x1E are unused: writes change nothing and make no internal access, and reads return 0.
- R10: A request is accepted only while the block is idle and m_ack is low. Accesses that make no internal access are acknowledged in the cycle after acceptance, and m_ack is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | 5 | Management register number |
| m_wdata | input | 16 | Management write data |
| m_wr | input | 1 | Write request, held until m_ack |
| m_rd | input | 1 | Read request, held until m_ack |
| m_rdata | output | 16 | Management read data, registered |
| m_ack | output | 1 | One-cycle access acknowledge |
| bus_addr | output | ADDR_W | Internal byte address, word aligned |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | Internal write request |
| bus_re | output | 1 | Internal read request |
| bus_rdata | input | 32 | Internal read data, valid with bus_ready |
| bus_ready | input | 1 | Internal access complete |
| err_sticky | output | 1 | Orphan high-half write seen |

## Verification
The bench builds the block with ADDR_W of 16, which gives a 10-bit page. Writing page values with all bits set, and 16-bit values with bits above the page width set, reaches the top page and checks that the extra bits are dropped. The bench's bus model takes a ready latency of 0, 1 or 3 cycles, so the stall length, the held request and the acknowledge cycle are checked at more than one delay. Changing the page between the low-word and high-word writes shows that the write address comes from the staged copy of the page.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam logic [4:0] REG_HIGH = 5'h10;
  localparam logic [4:0] REG_PAGE = 5'h1F;
  localparam int LOW_IDX_W = 4;

  typedef enum logic [1:0] {
    K_LOW  = 2'd0,
    K_HIGH = 2'd1,
    K_PAGE = 2'd2,
    K_NONE = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } bridge_st_e;
endpackage

// File: rtl/mdio_bridge_decode.sv
module mdio_bridge_decode
  import mdio_bridge_pkg::*;
(
  input  logic [4:0] reg_num,
  output reg_kind_e  kind
);
  always_comb begin
    if (reg_num[4] == 1'b0)       kind = K_LOW;
    else if (reg_num == REG_HIGH) kind = K_HIGH;
    else if (reg_num == REG_PAGE) kind = K_PAGE;
    else                          kind = K_NONE;
  end
endmodule

// File: rtl/mdio_bridge_hold.sv
module mdio_bridge_hold
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 page_we,
  input  logic [15:0]          page_d,
  input  logic                 low_we,
  input  logic [LOW_IDX_W-1:0] low_idx,
  input  logic [15:0]          low_d,
  input  logic                 pend_clr,
  input  logic                 shadow_we,
  input  logic [15:0]          shadow_d,
  output logic [PAGE_W-1:0]    page_q,
  output logic [15:0]          page_rd,
  output logic [15:0]          low_q,
  output logic [LOW_IDX_W-1:0] idx_q,
  output logic [PAGE_W-1:0]    pagecap_q,
  output logic                 pend_q,
  output logic [15:0]          shadow_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      low_q     <= '0;
      idx_q     <= '0;
      pagecap_q <= '0;
      pend_q    <= 1'b0;
      shadow_q  <= '0;
    end else begin
      if (page_we) page_q <= page_d[PAGE_W-1:0];
      if (low_we) begin
        low_q     <= low_d;
        idx_q     <= low_idx;
        pagecap_q <= page_q;
        pend_q    <= 1'b1;
      end else if (pend_clr) begin
        pend_q <= 1'b0;
      end
      if (shadow_we) shadow_q <= shadow_d;
    end
  end

  generate
    if (PAGE_W < 16) begin : g_pad
      assign page_rd = {{(16 - PAGE_W){1'b0}}, page_q};
    end else begin : g_trunc
      assign page_rd = page_q[15:0];
    end
  endgenerate

  assert_pend_staged_R5: assert property (@(posedge clk) disable iff (rst)
    (low_we && !page_we) |=> (pend_q && pagecap_q == $past(page_q)));
endmodule

// File: rtl/mdio_bridge_fsm.sv
module mdio_bridge_fsm
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = ADDR_W - 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [4:0]           m_addr,
  input  logic [15:0]          m_wdata,
  input  logic                 m_wr,
  input  logic                 m_rd,
  input  reg_kind_e            kind,
  input  logic [PAGE_W-1:0]    page_q,
  input  logic [15:0]          page_rd,
  input  logic [15:0]          low_q,
  input  logic [LOW_IDX_W-1:0] idx_q,
  input  logic [PAGE_W-1:0]    pagecap_q,
  input  logic                 pend_q,
  input  logic [15:0]          shadow_q,
  input  logic [31:0]          bus_rdata,
  input  logic                 bus_ready,
  output logic                 page_we,
  output logic                 low_we,
  output logic                 pend_clr,
  output logic                 shadow_we,
  output logic [15:0]          m_rdata,
  output logic                 m_ack,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [31:0]          bus_wdata,
  output logic                 bus_we,
  output logic                 bus_re,
  output logic                 err_sticky
);
  bridge_st_e state;
  logic start;

  assign start     = (m_wr || m_rd) && !m_ack && (state == ST_IDLE);
  assign page_we   = start && m_wr && (kind == K_PAGE);
  assign low_we    = start && m_wr && (kind == K_LOW);
  assign pend_clr  = start && m_wr && (kind == K_HIGH);
  assign shadow_we = (state == ST_RD) && bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      m_ack      <= 1'b0;
      m_rdata    <= '0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      bus_we     <= 1'b0;
      bus_re     <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      m_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (m_wr) begin
              if (kind == K_HIGH && pend_q) begin
                bus_we    <= 1'b1;
                bus_addr  <= {pagecap_q, idx_q, 2'b00};
                bus_wdata <= {m_wdata, low_q};
                state     <= ST_WR;
              end else begin
                if (kind == K_HIGH) err_sticky <= 1'b1;
                m_ack <= 1'b1;
              end
            end else begin
              case (kind)
                K_LOW: begin
                  bus_re   <= 1'b1;
                  bus_addr <= {page_q, m_addr[LOW_IDX_W-1:0], 2'b00};
                  state    <= ST_RD;
                end
                K_HIGH: begin m_rdata <= shadow_q; m_ack <= 1'b1; end
                K_PAGE: begin m_rdata <= page_rd;  m_ack <= 1'b1; end
                default: begin m_rdata <= '0;      m_ack <= 1'b1; end
              endcase
            end
          end
        end
        ST_RD: begin
          if (bus_ready) begin
            bus_re  <= 1'b0;
            m_rdata <= bus_rdata[15:0];
            m_ack   <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (bus_ready) begin
            bus_we <= 1'b0;
            m_ack  <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((bus_re || bus_we) && !bus_ready) |=>
      ((bus_re || bus_we) && $stable(bus_addr) && $stable(bus_wdata)));
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    m_ack |=> !m_ack);
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
  assert_rdata_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(m_rdata) |-> m_ack);
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        m_addr,
  input  logic [15:0]       m_wdata,
  input  logic              m_wr,
  input  logic              m_rd,
  output logic [15:0]       m_rdata,
  output logic              m_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ready,
  output logic              err_sticky
);
  localparam int PAGE_W = ADDR_W - 2 - LOW_IDX_W;

  reg_kind_e             kind;
  logic                  page_we, low_we, pend_clr, shadow_we, pend_q;
  logic [PAGE_W-1:0]     page_q, pagecap_q;
  logic [15:0]           page_rd, low_q, shadow_q;
  logic [LOW_IDX_W-1:0]  idx_q;

  mdio_bridge_decode u_dec (
    .reg_num (m_addr),
    .kind    (kind)
  );

  mdio_bridge_hold #(.PAGE_W(PAGE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .page_we   (page_we),
    .page_d    (m_wdata),
    .low_we    (low_we),
    .low_idx   (m_addr[LOW_IDX_W-1:0]),
    .low_d     (m_wdata),
    .pend_clr  (pend_clr),
    .shadow_we (shadow_we),
    .shadow_d  (bus_rdata[31:16]),
    .page_q    (page_q),
    .page_rd   (page_rd),
    .low_q     (low_q),
    .idx_q     (idx_q),
    .pagecap_q (pagecap_q),
    .pend_q    (pend_q),
    .shadow_q  (shadow_q)
  );

  mdio_bridge_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .m_wr       (m_wr),
    .m_rd       (m_rd),
    .kind       (kind),
    .page_q     (page_q),
    .page_rd    (page_rd),
    .low_q      (low_q),
    .idx_q      (idx_q),
    .pagecap_q  (pagecap_q),
    .pend_q     (pend_q),
    .shadow_q   (shadow_q),
    .bus_rdata  (bus_rdata),
    .bus_ready  (bus_ready),
    .page_we    (page_we),
    .low_we     (low_we),
    .pend_clr   (pend_clr),
    .shadow_we  (shadow_we),
    .m_rdata    (m_rdata),
    .m_ack      (m_ack),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .err_sticky (err_sticky)
  );
endmodule

// File: tb/sim_mdio_page_bridge.sv
module sim_mdio_page_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  m_addr = '0;
  logic [15:0] m_wdata = '0;
  logic        m_wr = 1'b0, m_rd = 1'b0;
  logic [15:0] m_rdata;
  logic        m_ack;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata = '0;
  logic        bus_ready = 1'b0;
  logic        err_sticky;

  int checks = 0, errors = 0;
  int lat = 0, cnt = 0;
  bit done = 0;

  typedef struct { bit we; logic [15:0] a; logic [31:0] d; } bus_t;
  bus_t expq[$];

  always #2 clk = ~clk;

  mdio_page_bridge #(.ADDR_W(16)) u0 (.*);

  function automatic logic [31:0] mdl(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic [15:0] ba(input logic [9:0] pg, input logic [3:0] ix);
    return {pg, ix, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // bus model and scoreboard monitor
  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 1'b0;
      cnt = 0;
    end else if (bus_re || bus_we) begin
      if (cnt >= lat) begin
        bus_ready = 1'b1;
        bus_rdata = mdl(bus_addr);
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected bus access actual we=%0d addr=%h expected none", bus_we, bus_addr);
        end else begin
          bus_t e;
          e = expq.pop_front();
          if (e.we !== bus_we || e.a !== bus_addr || (e.we && e.d !== bus_wdata)) begin
            errors++;
            $display("FAIL R3/R5 bus actual we=%0d a=%h d=%h expected we=%0d a=%h d=%h",
                     bus_we, bus_addr, bus_wdata, e.we, e.a, e.d);
          end
        end
      end else cnt++;
    end
  end

  task automatic acc(input bit wr, input logic [4:0] a, input logic [15:0] d,
                     output logic [15:0] rd, output int cyc);
    @(negedge clk);
    m_addr = a; m_wdata = d; m_wr = wr; m_rd = !wr;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!m_ack && cyc < 50);
    rd = m_rdata;
    m_wr = 1'b0; m_rd = 1'b0;
  endtask

  task automatic push(input bit we, input logic [15:0] a, input logic [31:0] d);
    bus_t e;
    e.we = we; e.a = a; e.d = d;
    expq.push_back(e);
  endtask

  initial begin
    repeat (400) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, prev;
    int cyc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ack", m_ack, 0);
    chk("R1 we", bus_we, 0);
    chk("R1 re", bus_re, 0);
    chk("R1 err", err_sticky, 0);
    chk("R1 rdata", m_rdata, 0);
    acc(0, 5'h1F, 0, rd, cyc);
    chk("R1 page", rd, 0);

    // page write drops bits above width
    lat = 0;
    acc(1, 5'h1F, 16'hFEAB, rd, cyc);
    chk("R10 local ack cycles", cyc, 1);
    acc(0, 5'h1F, 0, rd, cyc);
    chk("R2 page readback", rd, 16'h02AB);

    push(0, ba(10'h2AB, 4'h5), 0);
    acc(0, 5'h05, 0, rd, cyc);
    chk("R3 low data", rd, mdl(ba(10'h2AB, 4'h5)) & 32'hFFFF);
    chk("R6 lat0 cycles", cyc, 2);
    acc(0, 5'h10, 0, rd, cyc);
    chk("R4 high data", rd, mdl(ba(10'h2AB, 4'h5)) >> 16);
    chk("R10 high ack cycles", cyc, 1);

    lat = 3;
    acc(1, 5'h1F, 16'hFFFF, rd, cyc);
    push(0, ba(10'h3FF, 4'hF), 0);
    acc(0, 5'h0F, 0, rd, cyc);
    chk("R3 top page data", rd, mdl(ba(10'h3FF, 4'hF)) & 32'hFFFF);
    chk("R6 lat3 cycles", cyc, 5);
    prev = rd;

    acc(1, 5'h02, 16'h1234, rd, cyc);
    chk("R7 rdata held after write", rd, prev);
    chk("R5 no bus on low write", expq.size(), 0);
    acc(1, 5'h1F, 16'h0001, rd, cyc);
    push(1, ba(10'h3FF, 4'h2), 32'hBEEF1234);
    acc(1, 5'h10, 16'hBEEF, rd, cyc);
    chk("R5 write ack cycles", cyc, 5);
    chk("R8 no err", err_sticky, 0);
    chk("R5 write consumed", expq.size(), 0);

    acc(1, 5'h10, 16'h7777, rd, cyc);
    chk("R8 err set", err_sticky, 1);
    chk("R8 orphan ack cycles", cyc, 1);

    lat = 1;
    push(0, ba(10'h001, 4'h0), 0);
    acc(0, 5'h00, 0, rd, cyc);
    chk("R3 page1 data", rd, mdl(ba(10'h001, 4'h0)) & 32'hFFFF);
    chk("R6 lat1 cycles", cyc, 3);
    chk("R8 err sticky", err_sticky, 1);

    acc(1, 5'h15, 16'hFFFF, rd, cyc);
    acc(0, 5'h1F, 0, rd, cyc);
    chk("R9 page unchanged", rd, 16'h0001);
    acc(0, 5'h15, 0, rd, cyc);
    chk("R9 unused read zero", rd, 0);
    chk("R9 unused ack cycles", cyc, 1);
    repeat (3) @(negedge clk);
    chk("R5 scoreboard drained", expq.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule